// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a simple word-wide memory bus and an instruction consumer. It keeps a small byte queue stocked with code fetched ahead of use. Fetch addresses come from a 16-bit segment and a 16-bit offset: the segment is shifted up by four bits and the offset is added to give a 20-bit physical address. Every fetch bus cycle brings in one 16-bit word. The consumer removes bytes one at a time from the head of the queue.

The same bus carries operand transfers for the execution side. An operand request is served ahead of any new prefetch. A prefetch cycle that has already started on the bus always runs to its end, and the operand cycle is issued in the cycle right after it. A redirect input empties the queue and moves fetching to a new segment and offset. If a fetch was still waiting on the bus when the redirect arrived, the word it returns is thrown away.

Top module: `prefetch_queue_ctl`

## Requirements
- R1: The queue holds at most DEPTH (default 6) bytes and hands them out in the order they were fetched; a queue that fills from an even offset with no consumption holds exactly 6 bytes.
- R2: A fetch bus cycle begins only when at least two queue bytes will be free and `opReq` is low.
- R3: A fetch from an even offset loads two bytes: `memRdata[7:0]` first, then `memRdata[15:8]`. A fetch from an odd offset loads only `memRdata[15:8]` and advances the offset by one. Every other completed fetch advances the offset by two, modulo 2^16. A queue that fills from an odd target with no consumption therefore holds 5 bytes.
- R4: Each cycle with `byteTake` high and `byteValid` high removes exactly one byte. A byte loaded by a fetch acknowledged at edge E shows at `byteData` with `byteValid` high right after E, provided no older byte is waiting.
- R5: If `opReq` is high when a fetch cycle is acknowledged, the next cycle carries `memReq` high with the operand's address and controls.
- R6: A fetch drives `memAddr` = ((segment << 4) + offset) mod 2^20 with bit 0 cleared. After reset the segment is 16'hFFFF and the offset is 0, so the first fetch address is 20'hFFFF0.
- R7: When the queue cannot take two more bytes and `opReq` is low, `memReq` stays low.
- R8: A `branchValid` pulse empties the queue, so `byteValid` is low on the next cycle. Fetching restarts at `branchSeg`:`branchOff`. A word returned by a fetch that was pending when the pulse arrived is not loaded.
- R9: `byteValid` is low while the queue is empty, including during reset.
- R10: An operand cycle drives `memWrite` = `opWrite`, `memIo` = `opIo`, `memAddr` = `opAddr` and `memWdata` = `opWdata`. `opDone` is high in the cycle the bus acknowledges, and `opRdata` returns `memRdata` in that same cycle.
- R11: While `memReq` is high and `memAck` is low, the address and the controls of the cycle stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| branchValid | input | 1 | One-cycle redirect pulse |
| branchSeg | input | 16 | Redirect segment |
| branchOff | input | 16 | Redirect offset |
| byteTake | input | 1 | Consumer takes the head byte |
| byteValid | output | 1 | Head byte is valid |
| byteData | output | 8 | Head byte |
| opReq | input | 1 | Operand transfer requested, held until `opDone` |
| opWrite | input | 1 | Operand transfer is a write |
| opIo | input | 1 | Operand transfer targets I/O space |
| opAddr | input | 20 | Operand physical address |
| opWdata | input | 16 | Operand write data |
| opDone | output | 1 | Operand transfer acknowledged |
| opRdata | output | 16 | Operand read data |
| memReq | output | 1 | Bus cycle requested |
| memWrite | output | 1 | Bus cycle is a write |
| memIo | output | 1 | Bus cycle targets I/O space |
| memAddr | output | 20 | Bus address |
| memWdata | output | 16 | Bus write data |
| memAck | input | 1 | Bus cycle acknowledged |
| memRdata | input | 16 | Bus read data |

## Verification
Two events can land on the same edge: a fetch acknowledge, and either a pending operand request or a redirect. To provoke the first case, the bench stalls the memory model after a fetch has begun, raises an operand read, and then releases the stall. It then requires that the cycle after the fetch acknowledge carries the operand address. To provoke the second case, redirects are fired while a fetch is still waiting on the bus, across several wait-state settings and consumption rates. Every byte the consumer later takes is compared with a value derived arithmetically from its expected physical address, so a stale word from the dropped fetch would be detected.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_OPER  = 2'd2
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fill;       // load fetched word into queue, advance offset
    logic flush;      // empty queue, take redirect target
    logic latchAddr;  // capture next fetch address
  } dpStrobe_t;

endpackage

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_OFF = 16'h0000,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              byteTake,
  input  logic [SEG_W-1:0]  branchSeg,
  input  logic [SEG_W-1:0]  branchOff,
  input  logic [15:0]       memRdata,
  output logic              byteValid,
  output logic [7:0]        byteData,
  output logic [CNT_W-1:0]  roomBase,
  output logic [CNT_W-1:0]  fillBytes,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [CNT_W-1:0]  queueCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]        slotQ    [DEPTH];
  logic [7:0]        slotNext [DEPTH];
  logic [CNT_W-1:0]  countQ, countNext, baseCount;
  logic [SEG_W-1:0]  segQ, segNext, offQ, offNext;
  logic [ADDR_W-1:0] fetchAddrQ, physNext;
  logic              popNow, oddStart;
  logic [7:0]        firstByte;

  assign popNow    = byteTake && (countQ != '0);
  assign baseCount = countQ - CNT_W'(popNow);
  assign oddStart  = offQ[0];
  assign fillBytes = oddStart ? CNT_W'(1) : CNT_W'(2);
  assign roomBase  = FULL_CNT - baseCount;
  assign firstByte = oddStart ? memRdata[15:8] : memRdata[7:0];

  // Shift toward the head on a pop, then append behind the survivors
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slotNext[i] = (popNow && (i < DEPTH - 1)) ? slotQ[(i < DEPTH - 1) ? i + 1 : i]
                                                : slotQ[i];
      if (strobe.fill && (baseCount == CNT_W'(i))) begin
        slotNext[i] = firstByte;
      end else if (strobe.fill && !oddStart && (baseCount + CNT_W'(1) == CNT_W'(i))) begin
        slotNext[i] = memRdata[15:8];
      end
    end
  end

  always_comb begin
    if (strobe.flush) begin
      countNext = '0;
    end else if (strobe.fill) begin
      countNext = baseCount + fillBytes;
    end else begin
      countNext = baseCount;
    end
  end

  // Fetch pointer
  always_comb begin
    segNext = segQ;
    offNext = offQ;
    if (strobe.flush) begin
      segNext = branchSeg;
      offNext = branchOff;
    end else if (strobe.fill) begin
      offNext = offQ + (oddStart ? SEG_W'(1) : SEG_W'(2));
    end
  end

  assign physNext = {segNext, {SHIFT{1'b0}}} + ADDR_W'(offNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        slotQ[i] <= '0;
      end
      countQ     <= '0;
      segQ       <= RESET_SEG;
      offQ       <= RESET_OFF;
      fetchAddrQ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        slotQ[i] <= slotNext[i];
      end
      countQ <= countNext;
      segQ   <= segNext;
      offQ   <= offNext;
      if (strobe.latchAddr) begin
        fetchAddrQ <= {physNext[ADDR_W-1:1], 1'b0};
      end
    end
  end

  assign byteValid  = (countQ != '0);
  assign byteData   = slotQ[0];
  assign fetchAddr  = fetchAddrQ;
  assign queueCount = countQ;

endmodule

// File: rtl/pfq_control.sv
module pfq_control
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opReq,
  input  logic             memAck,
  input  logic             branchValid,
  input  logic [CNT_W-1:0] roomBase,
  input  logic [CNT_W-1:0] fillBytes,
  output dpStrobe_t        strobe,
  output busState_t        busState,
  output logic             opDone
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(2);

  busState_t        stateQ, stateNext;
  logic             dropQ, dropNext;
  logic             fetchAck, canFetch;
  logic [CNT_W-1:0] roomAfter;

  assign fetchAck = (stateQ == BUS_FETCH) && memAck;

  always_comb begin
    strobe.fill  = fetchAck && !dropQ && !branchValid;
    strobe.flush = branchValid;
  end

  assign roomAfter = branchValid ? FULL_CNT
                                 : roomBase - (strobe.fill ? fillBytes : '0);
  assign canFetch  = !branchValid && (roomAfter >= WORD_BYTES);

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      BUS_IDLE: begin
        if (opReq)         stateNext = BUS_OPER;
        else if (canFetch) stateNext = BUS_FETCH;
      end
      BUS_FETCH: begin
        if (memAck) begin
          if (opReq)         stateNext = BUS_OPER;
          else if (canFetch) stateNext = BUS_FETCH;
          else               stateNext = BUS_IDLE;
        end
      end
      BUS_OPER: begin
        if (memAck) begin
          stateNext = canFetch ? BUS_FETCH : BUS_IDLE;
        end
      end
      default: stateNext = BUS_IDLE;
    endcase
  end

  assign strobe.latchAddr = (stateNext == BUS_FETCH) &&
                            ((stateQ != BUS_FETCH) || memAck);

  always_comb begin
    dropNext = dropQ;
    if (fetchAck)                                 dropNext = 1'b0;
    else if (branchValid && stateQ == BUS_FETCH)  dropNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= BUS_IDLE;
      dropQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      dropQ  <= dropNext;
    end
  end

  assign busState = stateQ;
  assign opDone   = (stateQ == BUS_OPER) && memAck;

endmodule

// File: rtl/prefetch_queue_ctl.sv
module prefetch_queue_ctl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int SEG_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [SEG_W-1:0] RESET_OFF = 16'h0000,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              branchValid,
  input  logic [SEG_W-1:0]  branchSeg,
  input  logic [SEG_W-1:0]  branchOff,
  input  logic              byteTake,
  output logic              byteValid,
  output logic [7:0]        byteData,
  input  logic              opReq,
  input  logic              opWrite,
  input  logic              opIo,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [15:0]       opWdata,
  output logic              opDone,
  output logic [15:0]       opRdata,
  output logic              memReq,
  output logic              memWrite,
  output logic              memIo,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic              memAck,
  input  logic [15:0]       memRdata
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dpStrobe_t         strobe;
  busState_t         busState;
  logic [CNT_W-1:0]  roomBase, fillBytes, queueCount;
  logic [ADDR_W-1:0] fetchAddr;
  logic              operCycle;

  pfq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opReq      (opReq),
    .memAck     (memAck),
    .branchValid(branchValid),
    .roomBase   (roomBase),
    .fillBytes  (fillBytes),
    .strobe     (strobe),
    .busState   (busState),
    .opDone     (opDone)
  );

  pfq_datapath #(
    .DEPTH    (DEPTH),
    .SEG_W    (SEG_W),
    .SHIFT    (SHIFT),
    .RESET_SEG(RESET_SEG),
    .RESET_OFF(RESET_OFF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteTake  (byteTake),
    .branchSeg (branchSeg),
    .branchOff (branchOff),
    .memRdata  (memRdata),
    .byteValid (byteValid),
    .byteData  (byteData),
    .roomBase  (roomBase),
    .fillBytes (fillBytes),
    .fetchAddr (fetchAddr),
    .queueCount(queueCount)
  );

  assign operCycle = (busState == BUS_OPER);
  assign memReq    = (busState != BUS_IDLE);
  assign memWrite  = operCycle && opWrite;
  assign memIo     = operCycle && opIo;
  assign memAddr   = operCycle ? opAddr : fetchAddr;
  assign memWdata  = opWdata;
  assign opRdata   = memRdata;

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic              memWrite,
  input logic              memIo,
  input logic [ADDR_W-1:0] memAddr,
  input logic              opReq,
  input logic              branchValid,
  input logic              byteValid,
  input logic [CNT_W-1:0]  queueCount,
  input busState_t         busState,
  input logic              latchAddr
);

  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ROOM2_CNT = CNT_W'(DEPTH - 2);

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memIo)));

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueCount <= FULL_CNT);

  // R2
  fetch_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchAddr |=> (queueCount <= ROOM2_CNT));

  // R2
  fetch_yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchAddr && busState != BUS_OPER) |-> !opReq);

  // R5
  oper_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busState == BUS_FETCH && memAck && opReq) |=> (memReq && busState == BUS_OPER));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |=> !byteValid);

endmodule

bind prefetch_queue_ctl pfq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memAck     (memAck),
  .memWrite   (memWrite),
  .memIo      (memIo),
  .memAddr    (memAddr),
  .opReq      (opReq),
  .branchValid(branchValid),
  .byteValid  (byteValid),
  .queueCount (queueCount),
  .busState   (busState),
  .latchAddr  (strobe.latchAddr)
);

// File: tb/tb_prefetch_queue_ctl.sv
`timescale 1ns/1ps
module tb_prefetch_queue_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        branchValid = 1'b0;
  logic [15:0] branchSeg = '0, branchOff = '0;
  logic        byteTake = 1'b0;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        opReq = 1'b0, opWrite = 1'b0, opIo = 1'b0;
  logic [19:0] opAddr = '0;
  logic [15:0] opWdata = '0;
  logic        opDone;
  logic [15:0] opRdata;
  logic        memReq, memWrite, memIo;
  logic [19:0] memAddr;
  logic [15:0] memWdata;
  logic        memAck = 1'b0;
  logic [15:0] memRdata = '0;

  prefetch_queue_ctl dut (
    .clk(clk), .rstN(rstN),
    .branchValid(branchValid), .branchSeg(branchSeg), .branchOff(branchOff),
    .byteTake(byteTake), .byteValid(byteValid), .byteData(byteData),
    .opReq(opReq), .opWrite(opWrite), .opIo(opIo), .opAddr(opAddr),
    .opWdata(opWdata), .opDone(opDone), .opRdata(opRdata),
    .memReq(memReq), .memWrite(memWrite), .memIo(memIo), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always #4 clk = ~clk;

  int totalChecks = 0;
  int failedChecks = 0;
  int cyc = 0;
  int takeMode = 0;
  int waitCyc = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;
  logic [15:0] expSeg = 16'hFFFF;
  logic [15:0] expOff = 16'h0000;
  logic [19:0] lastWAddr = '0;
  logic [15:0] lastWData = '0;
  logic        lastWIo = 1'b0;

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    return {s, 4'b0} + {4'b0, o};
  endfunction

  function automatic logic [7:0] byteOf(logic [19:0] p);
    return p[7:0] ^ p[15:8] ^ {p[19:16], p[19:16]};
  endfunction

  function automatic logic [15:0] wordAt(logic [19:0] a);
    return {byteOf({a[19:1], 1'b1}), byteOf({a[19:1], 1'b0})};
  endfunction

  task automatic check(bit ok, string req, longint actual, longint expected);
    totalChecks++;
    if (!ok) begin
      failedChecks++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalChecks - failedChecks, totalChecks);
  endtask

  // Memory model: answers after waitCyc idle cycles unless stalled
  int waitCnt = 0;
  always @(posedge clk) begin
    #1;
    if (!rstN) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memReq && !stall) begin
      if (waitCnt >= waitCyc) begin
        memAck = 1'b1;
        if (memWrite) begin
          lastWAddr = memAddr;
          lastWData = memWdata;
          lastWIo   = memIo;
        end else begin
          memRdata = memIo ? ~memAddr[15:0] : wordAt(memAddr);
        end
      end else begin
        waitCnt++;
      end
    end
  end

  function automatic bit wantTake();
    if (takeMode == 0) return 1'b0;
    if (takeMode == 1) return 1'b1;
    return (cyc % takeMode) == 0;
  endfunction

  // One cycle: consumer compares the head byte with its address-derived value
  task automatic step();
    @(negedge clk);
    cyc++;
    branchValid = 1'b0;
    if (byteValid && wantTake()) begin
      // R1 R4: in-order bytes matching sequential addresses
      check(byteData == byteOf(phys(expSeg, expOff)), "R1", byteData, byteOf(phys(expSeg, expOff)));
      expOff++;
      byteTake = 1'b1;
    end else begin
      byteTake = 1'b0;
    end
  endtask

  task automatic doBranch(logic [15:0] s, logic [15:0] o);
    @(negedge clk);
    cyc++;
    branchValid = 1'b1;
    branchSeg = s;
    branchOff = o;
    byteTake = 1'b0;
    expSeg = s;
    expOff = o;
  endtask

  task automatic runConfig(logic [15:0] s, logic [15:0] o, int w);
    int highs;
    int taken;
    waitCyc = w;
    stall = 1'b0;
    takeMode = 0;
    repeat (40) step();
    highs = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      if (memReq) highs++;
    end
    // R7: no bus activity with a full queue
    check(highs == 0, "R7", highs, 0);
    doBranch(s, o);
    step();
    // R8 R9: queue empty after redirect
    check(byteValid == 1'b0, "R8", byteValid, 0);
    for (int k = 0; k < 30; k++) begin
      step();
      if (memAck) begin
        // R6: first fetch address after redirect
        check(memAddr == {phys(s, o)[19:1], 1'b0}, "R6", memAddr, {phys(s, o)[19:1], 1'b0});
        step();
        // R4: byte visible right after the acknowledge edge
        check(byteValid == 1'b1, "R4", byteValid, 1);
        break;
      end
    end
    repeat (40) step();
    stall = 1'b1;
    takeMode = 1;
    taken = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (byteTake) taken++;
      if (!byteValid) break;
    end
    // R1 R3: full occupancy is 6 from even, 5 from odd target
    check(taken == (o[0] ? 5 : 6), o[0] ? "R3" : "R1", taken, o[0] ? 5 : 6);
    stall = 1'b0;
    for (int m = 1; m <= 3; m++) begin
      takeMode = m;
      repeat (60) step();
      for (int k = 0; k < 20; k++) begin
        if (memReq && !memAck) break;
        step();
      end
      // R8: redirect while a fetch is pending; its word must be dropped
      doBranch(s + 16'(m), o + 16'(3 * m));
      repeat (60) step();
    end
    takeMode = 0;
  endtask

  task automatic opTest(bit wr, bit io, logic [19:0] a, logic [15:0] d);
    bit seen = 1'b0;
    takeMode = 1;
    step();
    opReq = 1'b1; opWrite = wr; opIo = io; opAddr = a; opWdata = d;
    for (int k = 0; k < 40; k++) begin
      step();
      if (opDone) begin
        seen = 1'b1;
        // R10: cycle type and address on the bus
        check(memAddr == a && memWrite == wr && memIo == io, "R10",
              {memAddr, memWrite, memIo}, {a, wr, io});
        if (!wr) begin
          check(opRdata == (io ? ~a[15:0] : wordAt(a)), "R10", opRdata,
                io ? ~a[15:0] : wordAt(a));
        end
        opReq = 1'b0;
        break;
      end
    end
    check(seen, "R10", seen, 1);
    step();
    if (wr) begin
      check(lastWAddr == a && lastWData == d && lastWIo == io, "R10",
            {lastWIo, lastWAddr, lastWData}, {io, a, d});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(byteValid == 1'b0, "R9", byteValid, 0);
    check(memReq == 1'b0, "R9", memReq, 0);
    rstN = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      if (memReq) begin
        // R6: first fetch after reset at FFFF0
        check(memAddr == 20'hFFFF0, "R6", memAddr, 20'hFFFF0);
        break;
      end
    end

    for (int w = 0; w < 4; w++) begin
      runConfig(16'h1234, 16'h0010, w);
      runConfig(16'h0F00, 16'hFFFE, w);   // offset wrap
      runConfig(16'hABCD, 16'h0007, w);   // odd target
      runConfig(16'hFFFF, 16'hFFFD, w);   // 20-bit wrap, odd
    end

    waitCyc = 2;
    opTest(1'b0, 1'b0, 20'h3A5C4, 16'h0);
    opTest(1'b0, 1'b1, 20'h00062, 16'h0);
    opTest(1'b1, 1'b0, 20'h7F00E, 16'hBEEF);
    opTest(1'b1, 1'b1, 20'h00310, 16'h1357);

    // R5: operand raised during a stalled fetch follows it directly
    stall = 1'b1;
    takeMode = 1;
    for (int k = 0; k < 30; k++) begin
      step();
      if (memReq) break;
    end
    opReq = 1'b1; opWrite = 1'b0; opIo = 1'b0; opAddr = 20'h12345;
    repeat (3) step();
    check(memReq && memAddr != 20'h12345, "R5", memAddr, 0);
    waitCyc = 1;
    stall = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (memAck && !opDone) begin
        step();
        check(memReq && memAddr == 20'h12345 && !memWrite, "R5", memAddr, 20'h12345);
        break;
      end
    end
    for (int k = 0; k < 20; k++) begin
      step();
      if (opDone) begin
        check(opRdata == wordAt(20'h12345), "R10", opRdata, wordAt(20'h12345));
        opReq = 1'b0;
        break;
      end
    end
    repeat (80) step();

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      totalChecks++;
      failedChecks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

endmodule